// File: doc/BRIEF.md
# Permutation-Network Deflection Routing Stage

This block is the routing core of a bufferless mesh router. Four flits, one per input side (North, East, South, West), enter in a cycle. All of them leave on the four outputs in that same cycle, and the stage never stores or drops any of them. Each flit's wanted output comes from its destination coordinates by dimension-order routing: X is resolved first, then Y.

The routing fabric is a small permutation network built from two ranks of 2x2 cells. Each cell chooses a winner between its two flits and gives the winner the output on the side it wants. The other flit takes the remaining output, and a flit that loses in this way is deflected. A cell uses only its own inputs. The order of preference is:
- a valid flit over an empty slot;
- a golden flit over a normal one;
- between two golden flits, the lower sequence number;
- otherwise, one bit of a free-running LFSR.

Top module: `pdr_stage`

## Requirements
- R1: Every valid input flit appears unchanged on exactly one output in the same cycle, and the number of valid outputs equals the number of valid inputs. Flit layout, LSB first: payload [7:0], dst_x [10:8], dst_y [13:11], seq [16:14], golden [17], valid [18].
- R2: The wanted direction is derived from the destination. dst_x above the node X (default 3) means East, below means West. Otherwise dst_y above the node Y (default 4) means South, below means North. A flit whose destination is this node wants North.
- R3: A valid flit that is alone in the stage leaves on its wanted output.
- R4: A golden flit that meets no other golden flit leaves on its wanted output, whatever the other flits want.
- R5: When two valid golden flits meet in a cell, the one with the lower sequence number wins. On equal numbers the upper slot wins.
- R6: When two valid non-golden flits meet in a cell, a random bit decides the winner: 1 means the lower slot wins, 0 means the upper slot wins. Cell A uses LFSR bit 0, cell B bit 1, cell C bit 2 and cell D bit 3.
- R7: The LFSR is 16 bits wide and holds the seed 16'hACE1 while rst_n is low. On every rising clock edge out of reset it shifts left and takes in the XOR of bits 15, 13, 12 and 10.
- R8: The wiring is fixed:
  - First rank: cell A takes N in its upper slot and E in its lower slot. Cell B takes S upper and W lower.
  - First-rank outputs: upper outputs feed cell C and lower outputs feed cell D. A feeds the upper slot of each, B the lower slot.
  - Second rank: C drives N (upper) and S (lower). D drives E (upper) and W (lower).
  - Preferences: in the first rank, a flit wanting E or W prefers the lower output. In C, a flit wanting S prefers the lower output. In D, a flit wanting W prefers the lower output. All other flits prefer the upper output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the tie-break LFSR |
| rst_n | input | 1 | Active-low reset, loads the LFSR seed |
| in_n | input | 19 | Flit arriving from the North |
| in_e | input | 19 | Flit arriving from the East |
| in_s | input | 19 | Flit arriving from the South |
| in_w | input | 19 | Flit arriving from the West |
| out_n | output | 19 | Flit leaving to the North |
| out_e | output | 19 | Flit leaving to the East |
| out_s | output | 19 | Flit leaving to the South |
| out_w | output | 19 | Flit leaving to the West |

## Verification
The bench drives lone flits from every input toward every direction class, including X-before-Y and already-arrived destinations. A wrong route decode or a miswired cell would send one of these out on the wrong port. It sets a golden flit against three rivals that want the same port, and two golden flits with swapped sequence numbers. A design that preferred normal flits or compared the numbers backwards would deflect the golden flit. It forces contention in each of the four cells over many cycles, checked against an LFSR model from the seed in reset onward. A wrong bit-to-cell mapping or a stuck LFSR would pick the wrong winner. A random mix is checked every cycle for conservation, so a dropped or duplicated flit is caught.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_t;

    localparam int SIDE_FIRST = 0;
    localparam int SIDE_NS    = 1;
    localparam int SIDE_EW    = 2;

endpackage

// File: rtl/pdr_dor_calc.sv
module pdr_dor_calc
    import pdr_pkg::*;
#(
    parameter int X_W    = 3,
    parameter int Y_W    = 3,
    parameter int NODE_X = 3,
    parameter int NODE_Y = 4
) (
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output dir_t           want
);
    localparam logic [X_W-1:0] HERE_X = X_W'(NODE_X);
    localparam logic [Y_W-1:0] HERE_Y = Y_W'(NODE_Y);

    // X dimension resolved before Y; an arrived flit defaults to North
    always_comb begin
        if (dst_x > HERE_X)      want = DIR_E;
        else if (dst_x < HERE_X) want = DIR_W;
        else if (dst_y > HERE_Y) want = DIR_S;
        else                     want = DIR_N;
    end
endmodule

// File: rtl/pdr_lfsr.sv
module pdr_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1,
    parameter int              NRND = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NRND-1:0] rnd
);
    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_s;

    lfsr_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = {r_q.st[W-2:0], ^(r_q.st & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= SEED;
        else        r_q    <= r_d;
    end

    assign rnd = r_q.st[NRND-1:0];

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st != '0);

    // R7
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> !$stable(r_q.st));
endmodule

// File: rtl/pdr_swap_cell.sv
module pdr_swap_cell
    import pdr_pkg::*;
#(
    parameter int FLIT_W    = 19,
    parameter int VALID_BIT = 18,
    parameter int GOLD_BIT  = 17,
    parameter int SEQ_LSB   = 14,
    parameter int SEQ_W     = 3,
    parameter int SIDE      = SIDE_FIRST
) (
    input  logic [FLIT_W-1:0] up_flit,
    input  logic [FLIT_W-1:0] lo_flit,
    input  dir_t              up_dir,
    input  dir_t              lo_dir,
    input  logic              rnd,
    output logic [FLIT_W-1:0] o0_flit,
    output logic [FLIT_W-1:0] o1_flit,
    output dir_t              o0_dir,
    output dir_t              o1_dir
);
    logic             up_v, lo_v, up_g, lo_g;
    logic [SEQ_W-1:0] up_s, lo_s;
    logic             up_hi, lo_hi;
    logic             lo_wins, swap;

    assign up_v = up_flit[VALID_BIT];
    assign lo_v = lo_flit[VALID_BIT];
    assign up_g = up_flit[GOLD_BIT];
    assign lo_g = lo_flit[GOLD_BIT];
    assign up_s = up_flit[SEQ_LSB +: SEQ_W];
    assign lo_s = lo_flit[SEQ_LSB +: SEQ_W];

    // which output each flit prefers depends on where the cell sits
    generate
        if (SIDE == SIDE_FIRST) begin : g_first
            assign up_hi = (up_dir == DIR_E) || (up_dir == DIR_W);
            assign lo_hi = (lo_dir == DIR_E) || (lo_dir == DIR_W);
        end else if (SIDE == SIDE_NS) begin : g_ns
            assign up_hi = (up_dir == DIR_S);
            assign lo_hi = (lo_dir == DIR_S);
        end else begin : g_ew
            assign up_hi = (up_dir == DIR_W);
            assign lo_hi = (lo_dir == DIR_W);
        end
    endgenerate

    always_comb begin
        if (up_v && lo_v) begin
            if (up_g != lo_g)  lo_wins = lo_g;
            else if (up_g)     lo_wins = (lo_s < up_s);
            else               lo_wins = rnd;
        end else begin
            lo_wins = lo_v && !up_v;
        end
        swap = lo_wins ? !lo_hi : up_hi;
    end

    assign o0_flit = swap ? lo_flit : up_flit;
    assign o1_flit = swap ? up_flit : lo_flit;
    assign o0_dir  = swap ? lo_dir  : up_dir;
    assign o1_dir  = swap ? up_dir  : lo_dir;
endmodule

// File: rtl/pdr_stage.sv
module pdr_stage
    import pdr_pkg::*;
#(
    parameter int            X_W       = 3,
    parameter int            Y_W       = 3,
    parameter int            SEQ_W     = 3,
    parameter int            DATA_W    = 8,
    parameter int            NODE_X    = 3,
    parameter int            NODE_Y    = 4,
    parameter int            LFSR_W    = 16,
    parameter logic [15:0]   LFSR_TAPS = 16'hB400,
    parameter logic [15:0]   LFSR_SEED = 16'hACE1,
    localparam int           DX_LSB    = DATA_W,
    localparam int           DY_LSB    = DX_LSB + X_W,
    localparam int           SEQ_LSB   = DY_LSB + Y_W,
    localparam int           GOLD_BIT  = SEQ_LSB + SEQ_W,
    localparam int           VALID_BIT = GOLD_BIT + 1,
    localparam int           FLIT_W    = VALID_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] in_n,
    input  logic [FLIT_W-1:0] in_e,
    input  logic [FLIT_W-1:0] in_s,
    input  logic [FLIT_W-1:0] in_w,
    output logic [FLIT_W-1:0] out_n,
    output logic [FLIT_W-1:0] out_e,
    output logic [FLIT_W-1:0] out_s,
    output logic [FLIT_W-1:0] out_w
);
    localparam int NPORT = 4;
    localparam int NCELL = 4;

    logic [FLIT_W-1:0] fin  [NPORT];
    dir_t              din  [NPORT];
    logic [FLIT_W-1:0] mid  [2][2];
    dir_t              mdir [2][2];
    logic [FLIT_W-1:0] fout [NPORT];
    dir_t              odir [NPORT];
    logic [NPORT-1:0]  vin, gin, vout, gout;
    logic [NCELL-1:0]  rnd;

    assign fin[0] = in_n;
    assign fin[1] = in_e;
    assign fin[2] = in_s;
    assign fin[3] = in_w;

    pdr_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_W'(LFSR_TAPS)),
        .SEED (LFSR_W'(LFSR_SEED)),
        .NRND (NCELL)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            pdr_dor_calc #(
                .X_W    (X_W),
                .Y_W    (Y_W),
                .NODE_X (NODE_X),
                .NODE_Y (NODE_Y)
            ) u_dor (
                .dst_x (fin[p][DX_LSB +: X_W]),
                .dst_y (fin[p][DY_LSB +: Y_W]),
                .want  (din[p])
            );
            assign vin[p]  = fin[p][VALID_BIT];
            assign gin[p]  = fin[p][GOLD_BIT];
            assign vout[p] = fout[p][VALID_BIT];
            assign gout[p] = fout[p][GOLD_BIT];
        end

        // first rank: cell A (N,E) and cell B (S,W)
        for (genvar i = 0; i < 2; i++) begin : g_rank1
            pdr_swap_cell #(
                .FLIT_W    (FLIT_W),
                .VALID_BIT (VALID_BIT),
                .GOLD_BIT  (GOLD_BIT),
                .SEQ_LSB   (SEQ_LSB),
                .SEQ_W     (SEQ_W),
                .SIDE      (SIDE_FIRST)
            ) u_cell (
                .up_flit (fin[2*i]),
                .lo_flit (fin[2*i+1]),
                .up_dir  (din[2*i]),
                .lo_dir  (din[2*i+1]),
                .rnd     (rnd[i]),
                .o0_flit (mid[i][0]),
                .o1_flit (mid[i][1]),
                .o0_dir  (mdir[i][0]),
                .o1_dir  (mdir[i][1])
            );
        end

        // second rank: cell C drives N/S, cell D drives E/W
        for (genvar j = 0; j < 2; j++) begin : g_rank2
            pdr_swap_cell #(
                .FLIT_W    (FLIT_W),
                .VALID_BIT (VALID_BIT),
                .GOLD_BIT  (GOLD_BIT),
                .SEQ_LSB   (SEQ_LSB),
                .SEQ_W     (SEQ_W),
                .SIDE      ((j == 0) ? SIDE_NS : SIDE_EW)
            ) u_cell (
                .up_flit (mid[0][j]),
                .lo_flit (mid[1][j]),
                .up_dir  (mdir[0][j]),
                .lo_dir  (mdir[1][j]),
                .rnd     (rnd[2+j]),
                .o0_flit (fout[j]),
                .o1_flit (fout[j+2]),
                .o0_dir  (odir[j]),
                .o1_dir  (odir[j+2])
            );
        end
    endgenerate

    assign out_n = fout[0];
    assign out_e = fout[1];
    assign out_s = fout[2];
    assign out_w = fout[3];

    // R1
    flit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vin) == $countones(vout));

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_chk
            // R3
            lone_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(vin) == 1 && vin[p]) |->
                    (vout[din[p]] && fout[din[p]] == fin[p]));

            // R3
            exit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(vin) == 1 && vout[p]) |-> (odir[p] == dir_t'(p)));

            // R4
            golden_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(vin & gin) == 1 && vin[p] && gin[p]) |->
                    (vout[din[p]] && gout[din[p]]));
        end
    endgenerate
endmodule

// File: tb/sim_pdr_stage.sv
`timescale 1ns/1ps
module sim_pdr_stage;
    typedef logic [18:0]      flit_t;
    typedef logic [3:0][18:0] quad_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    flit_t in_n = '0, in_e = '0, in_s = '0, in_w = '0;
    flit_t out_n, out_e, out_s, out_w;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [15:0] m_lfsr;

    always #5 clk = ~clk;

    pdr_stage u0 (
        .clk(clk), .rst_n(rst_n),
        .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
        .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
    );

    // R7 behavioural LFSR
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    function automatic flit_t mk(bit g, int seq, int dx, int dy, int data);
        return {1'b1, g, 3'(seq), 3'(dy), 3'(dx), 8'(data)};
    endfunction

    // R2: 0=N 1=E 2=S 3=W
    function automatic int want(flit_t f);
        if (f[10:8] > 3) return 1;
        if (f[10:8] < 3) return 3;
        if (f[13:11] > 4) return 2;
        return 0;
    endfunction

    function automatic bit hi_side(int side, int d);
        if (side == 0) return (d == 1 || d == 3);
        if (side == 1) return (d == 2);
        return (d == 3);
    endfunction

    task automatic cellm(input flit_t a, input flit_t b, input bit r, input int side,
                         output flit_t o0, output flit_t o1);
        bit bw;
        flit_t w, l;
        if (a[18] && b[18]) begin
            if (a[17] != b[17])  bw = b[17];
            else if (a[17])      bw = (b[16:14] < a[16:14]);
            else                 bw = r;
        end else bw = b[18];
        w = bw ? b : a;
        l = bw ? a : b;
        if (hi_side(side, want(w))) begin o0 = l; o1 = w; end
        else                        begin o0 = w; o1 = l; end
    endtask

    task automatic route(input quad_t f, input logic [15:0] r, output quad_t o);
        flit_t a0, a1, b0, b1, t0, t1, t2, t3;
        cellm(f[0], f[1], r[0], 0, a0, a1);
        cellm(f[2], f[3], r[1], 0, b0, b1);
        cellm(a0, b0, r[2], 1, t0, t2);
        cellm(a1, b1, r[3], 2, t1, t3);
        o[0] = t0; o[1] = t1; o[2] = t2; o[3] = t3;
    endtask

    function automatic quad_t outs();
        quad_t q;
        q[0] = out_n; q[1] = out_e; q[2] = out_s; q[3] = out_w;
        return q;
    endfunction

    task automatic chk(input string tag, input flit_t act, input flit_t exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_cmp(input quad_t f);
        quad_t e, a;
        int mism = 0;
        route(f, m_lfsr, e);
        a = outs();
        for (int p = 0; p < 4; p++) begin
            if (e[p][18] ? (a[p] !== e[p]) : (a[p][18] !== 1'b0)) mism++;
        end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL R8 model act=%h exp=%h", a, e);
        end
        // R1 conservation, independent of routing
        for (int i = 0; i < 4; i++) begin
            if (f[i][18]) begin
                int hits = 0;
                for (int p = 0; p < 4; p++) if (a[p] === f[i]) hits++;
                total++;
                if (hits != 1) begin
                    bad++;
                    $display("FAIL R1 input %0d copies act=%0d exp=1", i, hits);
                end
            end
        end
    endtask

    task automatic apply(input quad_t f);
        @(posedge clk);
        #1;
        in_n = f[0]; in_e = f[1]; in_s = f[2]; in_w = f[3];
        #4;
        model_cmp(f);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        quad_t f, o;
        int dxs [6] = '{5, 1, 3, 3, 3, 6};
        int dys [6] = '{4, 4, 6, 1, 4, 0};
        int exd [6] = '{1, 3, 2, 0, 0, 1};

        // reset state: all empty gives all empty; seed bit0=1 picks lower slot in cell A
        repeat (2) @(posedge clk);
        #5;
        o = outs();
        for (int p = 0; p < 4; p++) chk("R1 reset empty", {18'b0, o[p][18]}, '0);
        @(posedge clk);
        #1;
        in_n = mk(0, 0, 5, 4, 8'h11);
        in_e = mk(0, 0, 5, 4, 8'h22);
        #4;
        chk("R7 seed picks E-slot (out_e)", out_e, mk(0, 0, 5, 4, 8'h22));
        chk("R7 seed deflects N-slot (out_n)", out_n, mk(0, 0, 5, 4, 8'h11));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        in_n = '0; in_e = '0;

        // R2 / R3: lone flits
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 6; k++) begin
                f = '0;
                f[i] = mk(0, 0, dxs[k], dys[k], 16 * i + k);
                apply(f);
                o = outs();
                chk($sformatf("R2 R3 lone in%0d dest%0d", i, k), o[exd[k]], f[i]);
            end
        end

        // R4: golden beats three rivals wanting the same port
        for (int c = 0; c < 8; c++) begin
            f[0] = mk(0, 1, 3, 1, 8'hA0);
            f[1] = mk(0, 2, 3, 2, 8'hA1);
            f[2] = mk(0, 3, 3, 0, 8'hA2);
            f[3] = mk(1, 4, 3, 1, 8'hA3);
            apply(f);
            chk("R4 golden W to N", out_n, f[3]);
            f[0] = mk(1, 0, 3, 7, 8'hB0);
            f[1] = mk(0, 0, 3, 6, 8'hB1);
            f[2] = mk(0, 0, 3, 5, 8'hB2);
            f[3] = mk(0, 0, 3, 7, 8'hB3);
            apply(f);
            chk("R4 golden N to S", out_s, f[0]);
        end

        // R5: two golden flits in cell A
        f = '0;
        f[0] = mk(1, 5, 6, 4, 8'hC0);
        f[1] = mk(1, 2, 6, 4, 8'hC1);
        apply(f);
        chk("R5 lower seq from E wins", out_e, f[1]);
        chk("R5 higher seq deflected", out_n, f[0]);
        f[0] = mk(1, 1, 6, 4, 8'hC2);
        f[1] = mk(1, 6, 6, 4, 8'hC3);
        apply(f);
        chk("R5 lower seq from N wins", out_e, f[0]);
        chk("R5 higher seq deflected", out_n, f[1]);

        // R6: random tie-break in each cell
        for (int c = 0; c < 12; c++) begin
            f = '0;
            f[0] = mk(0, 0, 6, 4, 8'hD0);
            f[1] = mk(0, 0, 6, 4, 8'hD1);
            apply(f);
            chk("R6 cell A bit0", out_e, m_lfsr[0] ? f[1] : f[0]);
            f = '0;
            f[2] = mk(0, 0, 0, 4, 8'hD2);
            f[3] = mk(0, 0, 0, 4, 8'hD3);
            apply(f);
            chk("R6 cell B bit1", out_w, m_lfsr[1] ? f[3] : f[2]);
            f = '0;
            f[0] = mk(0, 0, 3, 0, 8'hD4);
            f[2] = mk(0, 0, 3, 1, 8'hD5);
            apply(f);
            chk("R6 cell C bit2", out_n, m_lfsr[2] ? f[2] : f[0]);
            f = '0;
            f[1] = mk(0, 0, 7, 4, 8'hD6);
            f[3] = mk(0, 0, 5, 4, 8'hD7);
            apply(f);
            chk("R6 cell D bit3", out_e, m_lfsr[3] ? f[3] : f[1]);
        end

        // R1 / R8: random traffic against the model
        for (int c = 0; c < 1500; c++) begin
            for (int i = 0; i < 4; i++) begin
                if ($urandom_range(0, 9) < 7)
                    f[i] = mk($urandom_range(0, 9) == 0, $urandom_range(0, 7),
                              $urandom_range(0, 7), $urandom_range(0, 7),
                              {6'($urandom_range(0, 63)), 2'(i)});
                else
                    f[i] = '0;
            end
            apply(f);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule